// File: doc/BRIEF.md
# Priority Memory Select Decoder

This block turns raw region-match hits into memory chip selects for a microcontroller whose program fetches and data reads use separate strobes. Four hit lines come in: SRAM, peripheral I/O, secondary (boot) flash and main flash. When address windows overlap, a fixed priority picks a single winner. The winner's select then passes only if the active strobe may reach that memory.

The strobe permissions come from an 8-bit space-mapping register. The register takes a parameterised value at reset. Software can rewrite it at any time through a plain write port, which lets memories move between program space, data space or both while the system runs. One example is swapping main and boot flash between the two spaces. The register value is also driven out so that it can be read back.

Top module: `memsel_decoder`

## Requirements
- R1: After reset the map register, seen on `map_o`, holds parameter `RESET_MAP` with bits 6 and 5 cleared. The default is 8'h8B.
- R2: When `wr_en` is high at a rising clock edge, `map_o` shows the written value from that edge onward.
- R3: Bits 6 and 5 of `map_o` always read 0, and writes to those bits are ignored.
- R4: At most one select is high at a time. The priority is SRAM first, then peripheral I/O, then boot flash, then main flash. The select vector order is {main, boot, pio, ram}.
- R5: `hit_pio` takes part in arbitration only when map bit 7 is 1. When bit 7 is 0, the hit is ignored and lower regions can win.
- R6: On a data read (`data_rd`), main flash needs map bit 4 and boot flash needs map bit 3. SRAM and peripheral I/O are always permitted on a data read.
- R7: On a program fetch (`prog_fetch`), main flash needs map bit 2, boot flash needs bit 1 and SRAM needs bit 0. Peripheral I/O is never selected by a program fetch.
- R8: If the winning region is blocked for the active strobe, no select asserts. No lower-priority region is selected in its place.
- R9: With neither strobe active, all selects are low.
- R10: When both the SRAM and the enabled peripheral I/O hit, SRAM wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Map register write strobe |
| wr_data | input | 8 | Map register write data |
| map_o | output | 8 | Current map register value |
| hit_ram | input | 1 | SRAM window hit |
| hit_pio | input | 1 | Peripheral I/O window hit |
| hit_boot | input | 1 | Boot flash window hit |
| hit_main | input | 1 | Main flash window hit |
| prog_fetch | input | 1 | Program fetch strobe, active high |
| data_rd | input | 1 | Data read strobe, active high |
| sel_ram | output | 1 | SRAM select |
| sel_pio | output | 1 | Peripheral I/O select |
| sel_boot | output | 1 | Boot flash select |
| sel_main | output | 1 | Main flash select |

## Verification
A corrupted map bit shows up on `map_o` in the same cycle. It also shows up on the selects at the first access to the region that bit governs: a memory either appears where it is blocked or vanishes where it is allowed. A faulty priority chain shows up as two selects at once, or as a lower region chosen over a blocked winner, on the first overlapping hit pattern. Because the selects are combinational, every such fault is visible within the cycle that presents the stimulus.

// File: rtl/memsel_pkg.sv
package memsel_pkg;
  localparam int MAP_W    = 8;
  localparam int N_REGION = 4;
  // region index = priority order, 0 highest
  localparam int IDX_RAM  = 0;
  localparam int IDX_PIO  = 1;
  localparam int IDX_BOOT = 2;
  localparam int IDX_MAIN = 3;
  // map bit positions
  localparam int B_RAM_CODE  = 0;
  localparam int B_BOOT_CODE = 1;
  localparam int B_MAIN_CODE = 2;
  localparam int B_BOOT_DATA = 3;
  localparam int B_MAIN_DATA = 4;
  localparam int B_PIO_EN    = 7;
  localparam logic [MAP_W-1:0] MAP_USED = 8'h9F;
endpackage

// File: rtl/memsel_map_reg.sv
module memsel_map_reg
  import memsel_pkg::*;
#(
  parameter logic [MAP_W-1:0] RESET_VAL = 8'h8B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [MAP_W-1:0] wr_data,
  output logic             rst_sync_n,
  output logic [MAP_W-1:0] map_q
);
  localparam logic [MAP_W-1:0] RESET_MASKED = RESET_VAL & MAP_USED;

  logic             rst_meta_n;
  logic [MAP_W-1:0] map_d;

  // reset synchroniser: async assert, sync release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  always_comb begin
    map_d = map_q;
    if (wr_en) map_d = wr_data & MAP_USED;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) map_q <= RESET_MASKED;
    else             map_q <= map_d;
  end
endmodule

// File: rtl/memsel_prio.sv
module memsel_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  assign grant[0] = req[0];
  for (genvar i = 1; i < N; i++) begin : g_lvl
    assign grant[i] = req[i] & ~(|req[i-1:0]);
  end
endmodule

// File: rtl/memsel_gate.sv
module memsel_gate
  import memsel_pkg::*;
(
  input  logic [N_REGION-1:0] grant,
  input  logic [MAP_W-1:0]    map_q,
  input  logic                prog_fetch,
  input  logic                data_rd,
  output logic [N_REGION-1:0] sel
);
  logic [N_REGION-1:0] code_ok;
  logic [N_REGION-1:0] data_ok;

  always_comb begin
    code_ok           = '0;
    code_ok[IDX_RAM]  = map_q[B_RAM_CODE];
    code_ok[IDX_PIO]  = 1'b0;
    code_ok[IDX_BOOT] = map_q[B_BOOT_CODE];
    code_ok[IDX_MAIN] = map_q[B_MAIN_CODE];
    data_ok           = '0;
    data_ok[IDX_RAM]  = 1'b1;
    data_ok[IDX_PIO]  = 1'b1;
    data_ok[IDX_BOOT] = map_q[B_BOOT_DATA];
    data_ok[IDX_MAIN] = map_q[B_MAIN_DATA];
  end

  for (genvar i = 0; i < N_REGION; i++) begin : g_sel
    assign sel[i] = grant[i] & ((prog_fetch & code_ok[i]) | (data_rd & data_ok[i]));
  end
endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder
  import memsel_pkg::*;
#(
  parameter logic [7:0] RESET_MAP = 8'h8B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] map_o,
  input  logic       hit_ram,
  input  logic       hit_pio,
  input  logic       hit_boot,
  input  logic       hit_main,
  input  logic       prog_fetch,
  input  logic       data_rd,
  output logic       sel_ram,
  output logic       sel_pio,
  output logic       sel_boot,
  output logic       sel_main
);
  logic                rst_sync_n;
  logic [MAP_W-1:0]    map_q;
  logic [N_REGION-1:0] req;
  logic [N_REGION-1:0] grant;
  logic [N_REGION-1:0] sel;

  memsel_map_reg #(.RESET_VAL(RESET_MAP)) u_map (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rst_sync_n(rst_sync_n), .map_q(map_q)
  );

  always_comb begin
    req           = '0;
    req[IDX_RAM]  = hit_ram;
    req[IDX_PIO]  = hit_pio & map_q[B_PIO_EN];
    req[IDX_BOOT] = hit_boot;
    req[IDX_MAIN] = hit_main;
  end

  memsel_prio #(.N(N_REGION)) u_prio (.req(req), .grant(grant));

  memsel_gate u_gate (
    .grant(grant), .map_q(map_q), .prog_fetch(prog_fetch),
    .data_rd(data_rd), .sel(sel)
  );

  assign map_o    = map_q;
  assign sel_ram  = sel[IDX_RAM];
  assign sel_pio  = sel[IDX_PIO];
  assign sel_boot = sel[IDX_BOOT];
  assign sel_main = sel[IDX_MAIN];
endmodule

// File: rtl/memsel_chk.sv
module memsel_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] map_o,
  input logic       hit_ram,
  input logic       hit_pio,
  input logic       hit_boot,
  input logic       prog_fetch,
  input logic       data_rd,
  input logic       sel_ram,
  input logic       sel_pio,
  input logic       sel_boot,
  input logic       sel_main
);
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_en |=> (map_o == ($past(wr_data) & 8'h9F)));

  assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    map_o[6:5] == 2'b00);

  assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0({sel_main, sel_boot, sel_pio, sel_ram}));

  assert_main_lowest_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    sel_main |-> (!hit_ram && !hit_boot && !(hit_pio && map_o[7])));

  assert_pio_enabled_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    sel_pio |-> (map_o[7] && !hit_ram));

  assert_pio_no_fetch_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    sel_pio |-> data_rd);

  assert_boot_gated_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (sel_boot && !prog_fetch) |-> map_o[3]);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (!prog_fetch && !data_rd) |-> !(sel_ram || sel_pio || sel_boot || sel_main));
endmodule

bind memsel_decoder memsel_chk u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .wr_en(wr_en), .wr_data(wr_data),
  .map_o(map_o), .hit_ram(hit_ram), .hit_pio(hit_pio), .hit_boot(hit_boot),
  .prog_fetch(prog_fetch), .data_rd(data_rd), .sel_ram(sel_ram),
  .sel_pio(sel_pio), .sel_boot(sel_boot), .sel_main(sel_main)
);

// File: tb/memsel_decoder_tb.sv
module memsel_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] RST_MAP = 8'h8B;

  typedef struct {
    logic [3:0] sel;   // {main, boot, pio, ram}
    logic [7:0] map;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] map_o;
  logic hit_ram = 0, hit_pio = 0, hit_boot = 0, hit_main = 0;
  logic prog_fetch = 0, data_rd = 0;
  logic sel_ram, sel_pio, sel_boot, sel_main;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] model_map;
  exp_t q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memsel_decoder #(.RESET_MAP(RST_MAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .map_o(map_o),
    .hit_ram(hit_ram), .hit_pio(hit_pio), .hit_boot(hit_boot), .hit_main(hit_main),
    .prog_fetch(prog_fetch), .data_rd(data_rd), .sel_ram(sel_ram),
    .sel_pio(sel_pio), .sel_boot(sel_boot), .sel_main(sel_main)
  );

  function automatic logic [3:0] model(input logic [7:0] m, input logic r,
      input logic p, input logic b, input logic mn, input logic pf, input logic rd);
    logic [3:0] s;
    s = 4'b0000;
    if (r)               s[0] = rd | (pf & m[0]);
    else if (p && m[7])  s[1] = rd;
    else if (b)          s[2] = (rd & m[3]) | (pf & m[1]);
    else if (mn)         s[3] = (rd & m[4]) | (pf & m[2]);
    return s;
  endfunction

  task automatic apply(input logic r, input logic p, input logic b, input logic mn,
      input logic pf, input logic rd, input string tag);
    exp_t e;
    @(negedge clk);
    hit_ram = r; hit_pio = p; hit_boot = b; hit_main = mn;
    prog_fetch = pf; data_rd = rd;
    e.sel = model(model_map, r, p, b, mn, pf, rd);
    e.map = model_map;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic write_map(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_map = d & 8'h9F;
  endtask

  // monitor
  initial begin
    forever begin
      exp_t e;
      wait (q.size() > 0);
      #(CLK_PERIOD/4);
      e = q.pop_front();
      n_run++;
      if ({sel_main, sel_boot, sel_pio, sel_ram} !== e.sel || map_o !== e.map) begin
        n_fail++;
        $display("FAIL %s: sel=%b map=%h expected sel=%b map=%h", e.tag,
                 {sel_main, sel_boot, sel_pio, sel_ram}, map_o, e.sel, e.map);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    model_map = RST_MAP & 8'h9F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    apply(0,0,0,0,0,0, "R1 reset value");
    apply(1,0,1,1,0,0, "R9 idle no strobe");
    apply(1,1,1,1,0,1, "R10 ram over pio");
    apply(0,1,1,1,0,1, "R4 pio over boot");
    apply(0,0,1,1,0,1, "R6 boot data allowed");
    apply(0,0,1,1,1,0, "R7 boot fetch allowed");
    apply(0,0,0,1,0,1, "R6 main data blocked");
    apply(0,0,0,1,1,0, "R7 main fetch blocked");
    apply(1,0,0,0,1,0, "R7 ram fetch allowed");
    apply(0,1,0,0,1,0, "R7 pio never fetched");
    write_map(8'h7F);
    apply(0,0,0,0,0,0, "R3 unused bits dropped");
    apply(0,1,1,0,0,1, "R5 pio ignored when disabled");
    apply(0,1,0,1,0,1, "R5 main wins over disabled pio");
    write_map(8'h94);
    apply(0,0,0,0,0,0, "R2 write visible");
    apply(0,0,1,1,0,1, "R8 boot blocked no fallback");
    apply(0,0,1,1,1,0, "R8 boot fetch blocked");
    apply(0,0,0,1,0,1, "R6 main data after swap");
    apply(0,0,0,1,1,0, "R7 main fetch after swap");
    apply(1,0,1,1,1,0, "R8 ram fetch blocked");
    apply(1,0,0,0,0,1, "R6 ram data always");
    apply(0,1,0,0,0,1, "R6 pio data");
    write_map(8'h0A);
    apply(0,0,1,0,1,1, "R7 both strobes boot");
    apply(0,0,0,0,1,1, "R9 no hits");
    @(negedge clk);
    hit_ram = 0; hit_pio = 0; hit_boot = 0; hit_main = 0;
    prog_fetch = 0; data_rd = 0;
    wait (q.size() == 0);
    #(CLK_PERIOD);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule